// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides when the clocks of a small 8-bit microcontroller run. Software writes a two-bit power register. Setting the doze bit stops only the CPU clock. Setting the halt bit stops the oscillator, and with it every clock. The block drives three enables, one for the CPU clock, one for the peripheral clock and one for the oscillator. It also reports the active mode on a two-bit status output.

Each low-power state has its own exit rule.

- **Doze:** a single wake request from the interrupt controller ends it. That request means an enabled interrupt is pending. The controller clears the doze bit on the same edge that turns the CPU clock back on.
- **Halt:** only the hardware reset pin ends it. Wake requests have no effect.
- **Reset arriving during doze:** the CPU resumes for a short grace window before the internal core reset takes over. The window lasts a parameterised number of machine cycles. It is timed on a divide-by-two phase of the input clock, so the input duty cycle does not matter. During the window the controller blocks RAM writes but still lets port writes through. RAM therefore keeps its contents across the reset.

Top module: `lowpwr_ctrl`

## Requirements
- R1: Between power-on reset release and any register write, the mode status reads 00 (run). The power register reads 00. The CPU, peripheral and oscillator enables all read 1, and the core reset output reads 0.
- R2: In run, a write whose bit 0 (doze) is 1 and bit 1 (halt) is 0 takes effect on the next cycle. The mode then reads 01, the CPU enable is 0, and the peripheral and oscillator enables are 1.
- R3: In run, a write with bit 1 (halt) set gives mode 10 on the next cycle, with all three enables 0. This holds whatever the value of bit 0, so halt wins over doze when both bits are set.
- R4: In doze, a wake request without hardware reset returns the block to run on the next cycle. The mode reads 00, the CPU enable reads 1, and power register bit 0 reads 0 on that same cycle.
- R5: A wake request has no effect in halt or in run. In halt the mode and the power register keep their values, and in run the mode stays 00.
- R6: Halt is left only through the hardware reset. The core reset output is 1 while the reset pin is held, then the block returns to run with the power register reading 00.
- R7: A hardware reset taking effect in doze opens a window of 2·RESUME_MCYC·MCYC_TICKS clock cycles. During the window the CPU enable is 1, the core reset is 0, the RAM write enable is 0 and the port write enable follows the port write request. On the cycle after the window, core reset goes to 1.
- R8: A hardware reset sampled in run asserts core reset on the next cycle, with no window.
- R9: In run, the RAM and port write enables follow their requests. While core reset is 1, both are 0.
- R10: A write to the power register outside run has no effect. After such a write in doze, the register still reads 01 and the mode still reads 01.
- R11: The mode status never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock from the oscillator |
| rstN | input | 1 | Power-on reset, asynchronous, active low |
| hwRst | input | 1 | Hardware reset pin, sampled, active high |
| pconWr | input | 1 | Write strobe for the power register |
| pconWrData | input | 2 | Write data: bit 0 is doze, bit 1 is halt |
| wakeReq | input | 1 | Wake request for an enabled interrupt |
| ramWrReq | input | 1 | RAM write request from the CPU |
| portWrReq | input | 1 | Port pin write request from the CPU |
| cpuClkEn | output | 1 | CPU clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| coreRst | output | 1 | Internal reset to the core |
| ramWrEn | output | 1 | Gated RAM write enable |
| portWrEn | output | 1 | Gated port write enable |
| pconRd | output | 2 | Current power register value |
| powerMode | output | 2 | Mode status: 00 run, 01 doze, 10 halt |

## Verification
The bench builds the block with MCYC_TICKS=3 and RESUME_MCYC=2. The grace window is then 12 clock cycles. Each window cycle can be checked on its own, and so can the first core-reset cycle that follows. The short count keeps the count-down and the phase divider in view, with phase restarted at window entry. Both parameters are small enough that an off-by-one in either the tick count or the phase would show up at the window's end.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_DOZE   = 3'd1,
    ST_HALT   = 3'd2,
    ST_WINDOW = 3'd3,
    ST_RESET  = 3'd4
  } lpmState_t;

  typedef struct packed {
    logic pconLoad;
    logic pconClr;
    logic dozeClr;
    logic winStart;
    logic winRun;
    logic oscRun;
  } lpmStrobe_t;

  localparam logic [1:0] MODE_RUN  = 2'b00;
  localparam logic [1:0] MODE_DOZE = 2'b01;
  localparam logic [1:0] MODE_HALT = 2'b10;

endpackage

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int MCYC_TICKS  = 6,
  parameter int RESUME_MCYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  lpmStrobe_t strb,
  input  logic [1:0] wrData,
  output logic [1:0] pcon,
  output logic       winDone
);
  localparam int WIN_TICKS = MCYC_TICKS * RESUME_MCYC;
  localparam int CNT_W     = $clog2(WIN_TICKS + 1);

  logic             phase;
  logic [CNT_W-1:0] winCnt;

  // power register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pcon <= 2'b00;
    else if (strb.pconClr)  pcon <= 2'b00;
    else if (strb.pconLoad) pcon <= wrData;
    else if (strb.dozeClr)  pcon[0] <= 1'b0;
  end

  // divide-by-two phase, restarted at window entry, frozen in halt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phase <= 1'b0;
    else if (strb.winStart) phase <= 1'b0;
    else if (strb.oscRun)   phase <= ~phase;
  end

  // grace window counter, one decrement per divided tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      winCnt <= '0;
    else if (strb.winStart)
      winCnt <= CNT_W'(WIN_TICKS);
    else if (strb.winRun && phase && (winCnt != '0))
      winCnt <= winCnt - 1'b1;
  end

  assign winDone = strb.winRun && phase && (winCnt == CNT_W'(1));

endmodule

// File: rtl/lpm_control.sv
module lpm_control
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hwRst,
  input  logic       pconWr,
  input  logic [1:0] pconWrData,
  input  logic       wakeReq,
  input  logic       ramWrReq,
  input  logic       portWrReq,
  input  logic       winDone,
  output lpmStrobe_t strb,
  output logic       cpuClkEn,
  output logic       periphClkEn,
  output logic       oscEn,
  output logic       coreRst,
  output logic       ramWrEn,
  output logic       portWrEn,
  output logic [1:0] powerMode
);
  lpmState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt      = state;
    strb          = '0;
    strb.oscRun   = (state != ST_HALT);
    strb.winRun   = (state == ST_WINDOW);
    unique case (state)
      ST_RUN: begin
        if (hwRst) begin
          stateNxt = ST_RESET;
        end else if (pconWr) begin
          strb.pconLoad = 1'b1;
          if (pconWrData[1])      stateNxt = ST_HALT;
          else if (pconWrData[0]) stateNxt = ST_DOZE;
        end
      end
      ST_DOZE: begin
        if (hwRst) begin
          stateNxt      = ST_WINDOW;
          strb.winStart = 1'b1;
        end else if (wakeReq) begin
          stateNxt     = ST_RUN;
          strb.dozeClr = 1'b1;
        end
      end
      ST_HALT: begin
        if (hwRst) stateNxt = ST_RESET;
      end
      ST_WINDOW: begin
        if (winDone) stateNxt = ST_RESET;
      end
      ST_RESET: begin
        strb.pconClr = 1'b1;
        if (!hwRst) stateNxt = ST_RUN;
      end
      default: stateNxt = ST_RESET;
    endcase
  end

  always_comb begin
    cpuClkEn    = (state == ST_RUN) || (state == ST_WINDOW) || (state == ST_RESET);
    periphClkEn = (state != ST_HALT);
    oscEn       = (state != ST_HALT);
    coreRst     = (state == ST_RESET);
    ramWrEn     = ramWrReq && ((state == ST_RUN));
    portWrEn    = portWrReq && ((state == ST_RUN) || (state == ST_WINDOW));
    case (state)
      ST_DOZE: powerMode = MODE_DOZE;
      ST_HALT: powerMode = MODE_HALT;
      default: powerMode = MODE_RUN;
    endcase
  end

endmodule

// File: rtl/lowpwr_ctrl.sv
module lowpwr_ctrl
  import lpm_pkg::*;
#(
  parameter int MCYC_TICKS  = 6,
  parameter int RESUME_MCYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hwRst,
  input  logic       pconWr,
  input  logic [1:0] pconWrData,
  input  logic       wakeReq,
  input  logic       ramWrReq,
  input  logic       portWrReq,
  output logic       cpuClkEn,
  output logic       periphClkEn,
  output logic       oscEn,
  output logic       coreRst,
  output logic       ramWrEn,
  output logic       portWrEn,
  output logic [1:0] pconRd,
  output logic [1:0] powerMode
);
  lpmStrobe_t strb;
  logic       winDone;

  lpm_control u_ctl (
    .clk(clk), .rstN(rstN), .hwRst(hwRst), .pconWr(pconWr),
    .pconWrData(pconWrData), .wakeReq(wakeReq), .ramWrReq(ramWrReq),
    .portWrReq(portWrReq), .winDone(winDone), .strb(strb),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .oscEn(oscEn),
    .coreRst(coreRst), .ramWrEn(ramWrEn), .portWrEn(portWrEn),
    .powerMode(powerMode)
  );

  lpm_datapath #(.MCYC_TICKS(MCYC_TICKS), .RESUME_MCYC(RESUME_MCYC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(pconWrData),
    .pcon(pconRd), .winDone(winDone)
  );

endmodule

// File: rtl/lowpwr_ctrl_chk.sv
module lowpwr_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hwRst,
  input logic       wakeReq,
  input logic       cpuClkEn,
  input logic       periphClkEn,
  input logic       oscEn,
  input logic       coreRst,
  input logic       ramWrEn,
  input logic [1:0] pconRd,
  input logic [1:0] powerMode
);
  AST_DOZE_CLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (powerMode == 2'b01) |-> (!cpuClkEn && periphClkEn && oscEn)); // R2
  AST_HALT_CLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (powerMode == 2'b10) |-> (!cpuClkEn && !periphClkEn && !oscEn)); // R3
  AST_WAKE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (powerMode == 2'b01 && wakeReq && !hwRst) |=> (powerMode == 2'b00 && cpuClkEn && !pconRd[0])); // R4
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (powerMode == 2'b10 && !hwRst) |=> (powerMode == 2'b10)); // R6
  AST_WINDOW_RAM: assert property (@(posedge clk) disable iff (!rstN)
    (powerMode == 2'b01 && hwRst) |=> (!ramWrEn && !coreRst && cpuClkEn)); // R7
  AST_RST_NO_RAM: assert property (@(posedge clk) disable iff (!rstN)
    coreRst |-> !ramWrEn); // R9
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    powerMode != 2'b11); // R11
endmodule

bind lowpwr_ctrl lowpwr_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .hwRst(hwRst), .wakeReq(wakeReq),
  .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .oscEn(oscEn),
  .coreRst(coreRst), .ramWrEn(ramWrEn), .pconRd(pconRd), .powerMode(powerMode)
);

// File: tb/tb_lowpwr_ctrl.sv
module tb_lowpwr_ctrl;
  localparam int MT = 3;
  localparam int RM = 2;
  localparam int WIN = 2 * RM * MT;

  logic clk = 1'b0;
  logic rstN, hwRst, pconWr, wakeReq, ramWrReq, portWrReq;
  logic [1:0] pconWrData;
  logic cpuClkEn, periphClkEn, oscEn, coreRst, ramWrEn, portWrEn;
  logic [1:0] pconRd, powerMode;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lowpwr_ctrl #(.MCYC_TICKS(MT), .RESUME_MCYC(RM)) dut (
    .clk(clk), .rstN(rstN), .hwRst(hwRst), .pconWr(pconWr),
    .pconWrData(pconWrData), .wakeReq(wakeReq), .ramWrReq(ramWrReq),
    .portWrReq(portWrReq), .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn),
    .oscEn(oscEn), .coreRst(coreRst), .ramWrEn(ramWrEn), .portWrEn(portWrEn),
    .pconRd(pconRd), .powerMode(powerMode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // wait one edge, sample shortly after
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idleIn();
    @(negedge clk);
    pconWr = 0; pconWrData = 0; wakeReq = 0; hwRst = 0;
    ramWrReq = 0; portWrReq = 0;
  endtask

  task automatic doReset();
    @(negedge clk); hwRst = 1;
    step(); step();
    @(negedge clk); hwRst = 0;
    step(); step();
  endtask

  task automatic writePcon(input logic [1:0] v);
    @(negedge clk); pconWr = 1; pconWrData = v;
    step();
    @(negedge clk); pconWr = 0; pconWrData = 0;
  endtask

  task automatic tReset();
    chk("R1 mode", powerMode, 0);
    chk("R1 pcon", pconRd, 0);
    chk("R1 enables", {cpuClkEn, periphClkEn, oscEn}, 7);
    chk("R1 coreRst", coreRst, 0);
  endtask

  task automatic tRunGating();
    @(negedge clk); ramWrReq = 1; portWrReq = 1; #1;
    chk("R9 ram pass", ramWrEn, 1);
    chk("R9 port pass", portWrEn, 1);
    ramWrReq = 0; #1;
    chk("R9 ram follow", ramWrEn, 0);
    idleIn();
  endtask

  task automatic tDozeWake();
    writePcon(2'b01);
    chk("R2 mode", powerMode, 1);
    chk("R2 enables", {cpuClkEn, periphClkEn, oscEn}, 3);
    // write in doze ignored
    @(negedge clk); pconWr = 1; pconWrData = 2'b10;
    step();
    @(negedge clk); pconWr = 0;
    chk("R10 pcon", pconRd, 1);
    chk("R10 mode", powerMode, 1);
    @(negedge clk); wakeReq = 1;
    step();
    chk("R4 mode", powerMode, 0);
    chk("R4 cpuEn", cpuClkEn, 1);
    chk("R4 pcon bit0", pconRd[0], 0);
    @(negedge clk); wakeReq = 1;
    step();
    chk("R5 run wake", powerMode, 0);
    idleIn();
  endtask

  task automatic tHalt(input logic [1:0] v);
    writePcon(v);
    chk("R3 mode", powerMode, 2);
    chk("R3 enables", {cpuClkEn, periphClkEn, oscEn}, 0);
    @(negedge clk); wakeReq = 1;
    step(); step();
    chk("R5 halt wake mode", powerMode, 2);
    chk("R5 halt wake pcon", pconRd, v);
    @(negedge clk); wakeReq = 0; hwRst = 1;
    step();
    chk("R6 coreRst", coreRst, 1);
    @(negedge clk); ramWrReq = 1; portWrReq = 1; #1;
    chk("R9 rst ram", ramWrEn, 0);
    chk("R9 rst port", portWrEn, 0);
    @(negedge clk); hwRst = 0; ramWrReq = 0; portWrReq = 0;
    step();
    chk("R6 mode", powerMode, 0);
    chk("R6 pcon", pconRd, 0);
    chk("R6 coreRst off", coreRst, 0);
    idleIn();
  endtask

  task automatic tWindow();
    writePcon(2'b01);
    @(negedge clk); hwRst = 1; ramWrReq = 1; portWrReq = 1;
    for (int i = 0; i < WIN; i++) begin
      step();
      chk("R7 win cpuEn", cpuClkEn, 1);
      chk("R7 win coreRst", coreRst, 0);
      chk("R7 win ram", ramWrEn, 0);
      chk("R7 win port", portWrEn, 1);
    end
    step();
    chk("R7 end coreRst", coreRst, 1);
    @(negedge clk); hwRst = 0; ramWrReq = 0; portWrReq = 0;
    step();
    chk("R7 back run", powerMode, 0);
    idleIn();
  endtask

  task automatic tRunReset();
    @(negedge clk); hwRst = 1;
    step();
    chk("R8 coreRst", coreRst, 1);
    @(negedge clk); hwRst = 0;
    step();
    chk("R8 release", coreRst, 0);
    idleIn();
  endtask

  initial begin
    rstN = 0; hwRst = 0; pconWr = 0; pconWrData = 0;
    wakeReq = 0; ramWrReq = 0; portWrReq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    step();
    tReset();
    tRunGating();
    tDozeWake();
    tHalt(2'b10);
    tHalt(2'b11);
    tWindow();
    tRunReset();
    doReset();
    chk("R11 mode legal", (powerMode == 2'b11) ? 1 : 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule